// File: doc/BRIEF.md
# Byte-parallel configuration slave serializer

This block is the slave end of a byte-wide configuration port. An external configuration clock drives it. The block takes one byte from a parallel data bus into a shift register and acknowledges that byte with a one-clock pulse. It then streams the byte out, most significant bit first, on a serial output that feeds the next device in a daisy chain. While a byte is in flight, the next capture slot falls exactly one byte-length of clocks after the previous capture. This keeps back-to-back bytes in a continuous bitstream with no gaps.

The serial output is retimed to the falling clock edge. A downstream device sampling on rising edges therefore sees each bit settled half a cycle earlier. The last byte of a load is tagged by its producer. After that byte is captured, a status output reports when enough additional clocks have elapsed to flush the chain. The count is a base number of edges plus one edge per chained device.

The port is active only when the mode select carries its enabling code. While the device is still initialising, the acknowledge pin reads high, as if held by a weak pull-up.

Top module: `cfg_slave_serializer`

## Requirements
- R1: The block is enabled only when `mode_sel` equals 3'b011. For any other code it captures nothing and drives `ser_out` low from the falling edge after the first rising edge that sees that code. Any byte in flight is dropped.
- R2: When enabled, with `init_done` high and no byte in flight, a byte presented with `byte_valid` high is captured on the next rising edge. This holds for any rising edge.
- R3: While a byte is in flight, the next capture opportunity is the rising edge exactly DATA_W (8) edges after the previous capture. `byte_valid` and `data_in` on all edges in between are ignored.
- R4: A capture raises `byte_taken` and `ack_out` on the capture edge. Both stay high for exactly one clock period.
- R5: While `init_done` is low, `ack_out` reads 1 and no byte is captured. Once `init_done` is high, `ack_out` follows the acknowledge pulse.
- R6: Bit 7-j of a byte captured on rising edge c is driven on `ser_out` from the falling edge after edge c+1+j, for j = 0..7. The MSB therefore appears 1.5 clocks after capture, and back-to-back bytes form an unbroken stream.
- R7: If `byte_valid` is low on a capture slot edge, no acknowledge is given. Once the last bit has been shifted out, `ser_out` returns to the idle level 1. This idle level holds whenever the block is enabled with nothing in flight.
- R8: After a byte captured with `last_byte` high on edge c, `flush_done` rises on edge c+10+CHAIN_LEN and stays high. It is cleared by the next capture or by reset.
- R9: `prog_n` low is a synchronous reset. It clears the shift register, the slot counter, the acknowledge flop and the flush timer, and holds `ser_out` low. After release the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | External configuration clock |
| prog_n | input | 1 | Synchronous active-low program/reset |
| init_done | input | 1 | High once initialisation has released the port |
| mode_sel | input | 3 | Mode code; 3'b011 enables the port |
| data_in | input | DATA_W (8) | Parallel configuration byte |
| byte_valid | input | 1 | A byte is present on `data_in` |
| last_byte | input | 1 | The presented byte is the final one of the load |
| ser_out | output | 1 | Serial daisy-chain data, changes on falling edges |
| ack_out | output | 1 | Acknowledge pin, one-clock pulse per byte, reads 1 before init |
| byte_taken | output | 1 | Internal strobe, one-clock pulse per captured byte |
| flush_done | output | 1 | Required flush clocks have elapsed after the last byte |

## Verification
The assertions check on every cycle that:
- an acknowledge never lasts more than one clock;
- two captures are never closer than a byte-length of edges;
- no acknowledge follows an edge without a presented byte;
- a disabling mode code forces the serial line low by the next rising edge;
- the flush status rises exactly the configured number of edges after the last capture.

Only the bench scenarios can show the bit-exact content and ordering of the serial stream. The bench sweeps every byte value, with and without bus noise between slots. It also covers the return to idle-high after an empty slot, the pull-up reading before init, and recovery after a mid-byte program pulse.

// File: rtl/cfg_ser_pkg.sv
// Shared constants and types for the byte-parallel configuration slave
// serializer. Assumes a single configuration clock domain.
package cfg_ser_pkg;

    // Mode code that enables the synchronous byte-parallel slave port
    localparam logic [2:0] SYNC_PERIPH_MODE = 3'b011;

    // Byte slot state: waiting for a first byte, or shifting one out
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;

    // Number of rising edges needed after the last byte before the chain is flushed
    function automatic int flush_edges(input int base_edges, input int chain_len);
        return base_edges + chain_len;
    endfunction

endpackage

// File: rtl/cfg_slot_timer.sv
// Byte slot timer. Decides on which rising edge a byte is captured.
// When idle, any edge with a valid byte captures. When busy, only the edge
// DATA_W edges after the last capture may capture again. If that slot is
// empty, the timer returns to idle.
// Assumes rst_n already combines the program input with the mode enable.
module cfg_slot_timer
    import cfg_ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    input  logic byte_valid,
    output logic capture,
    output logic busy
);

    localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    slot_state_e      state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             slot_open;

    // Capture window is open when idle or on the final edge of a byte
    always_comb begin
        slot_open = (state_q == SLOT_IDLE) || (bit_cnt_q == LAST_CNT);
        capture   = rst_n && init_done && byte_valid && slot_open;
    end

    // Advance the per-byte edge counter and the idle/busy state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SLOT_IDLE;
            bit_cnt_q <= '0;
        end else if (capture) begin
            state_q   <= SLOT_BUSY;
            bit_cnt_q <= '0;
        end else if (state_q == SLOT_BUSY) begin
            if (bit_cnt_q == LAST_CNT) begin
                state_q   <= SLOT_IDLE;
                bit_cnt_q <= '0;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    assign busy = (state_q == SLOT_BUSY);

endmodule

// File: rtl/cfg_shift_path.sv
// Serial data path. Loads a captured byte and shifts it MSB first, one bit
// per rising edge, into a rising-edge bit register. A falling-edge flop
// retimes that bit onto the daisy-chain output. From capture to the MSB on
// the output this gives one and a half clocks.
// Assumes load and busy come from the slot timer. The idle level is 1 while
// enabled; reset or disable forces 0.
module cfg_shift_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [DATA_W-1:0] load_data,
    output logic              ser_out
);

    logic [DATA_W-1:0] shreg_q;
    logic              rise_bit_q;

    // Load a new byte on capture, otherwise shift left while a byte is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= load_data;
        end else if (busy) begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        end
    end

    // Select the next serial bit on the rising edge: MSB of the byte, or idle-high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_bit_q <= 1'b0;
        end else begin
            rise_bit_q <= busy ? shreg_q[DATA_W-1] : 1'b1;
        end
    end

    // Retime the serial bit onto the falling edge for the downstream device
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else begin
            ser_out <= rise_bit_q;
        end
    end

endmodule

// File: rtl/cfg_flush_timer.sv
// Flush timer. Arms when a byte marked as last is captured. It counts the
// following rising edges and raises done once FLUSH of them have passed.
// Assumes capture is a one-cycle strobe. Any capture restarts or disarms it.
module cfg_flush_timer #(
    parameter int FLUSH = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic last_in,
    output logic done
);

    localparam int               CNT_W    = $clog2(FLUSH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FLUSH - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Count edges after the last byte and latch done at the flush boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else if (capture) begin
            armed_q <= last_in;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else if (armed_q) begin
            if (cnt_q == LAST_CNT) begin
                done    <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_slave_serializer.sv
// Byte-parallel configuration slave serializer, top level.
// Captures bytes from a parallel bus on the external configuration clock and
// acknowledges each with a one-clock pulse. It forwards the bits serially,
// MSB first, on a falling-edge daisy-chain output, and reports when the
// post-load flush clocks have elapsed.
// Assumes all inputs are synchronous to cfg_clk. prog_n is a synchronous
// active-low reset. A non-enabling mode code acts as a reset on the datapath.
module cfg_slave_serializer
    import cfg_ser_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BASE_FLUSH = 10,
    parameter int CHAIN_LEN  = 1
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic              init_done,
    input  logic [2:0]        mode_sel,
    input  logic [DATA_W-1:0] data_in,
    input  logic              byte_valid,
    input  logic              last_byte,
    output logic              ser_out,
    output logic              ack_out,
    output logic              byte_taken,
    output logic              flush_done
);

    localparam int FLUSH = flush_edges(BASE_FLUSH, CHAIN_LEN);

    logic mode_ok;
    logic clear_n;
    logic capture;
    logic busy;
    logic ack_q;

    // Port is live only under the enabling mode code and with program released
    always_comb begin
        mode_ok = (mode_sel == SYNC_PERIPH_MODE);
        clear_n = prog_n && mode_ok;
    end

    cfg_slot_timer #(
        .DATA_W (DATA_W)
    ) i_slot_timer (
        .clk        (cfg_clk),
        .rst_n      (clear_n),
        .init_done  (init_done),
        .byte_valid (byte_valid),
        .capture    (capture),
        .busy       (busy)
    );

    cfg_shift_path #(
        .DATA_W (DATA_W)
    ) i_shift_path (
        .clk       (cfg_clk),
        .rst_n     (clear_n),
        .load      (capture),
        .busy      (busy),
        .load_data (data_in),
        .ser_out   (ser_out)
    );

    cfg_flush_timer #(
        .FLUSH (FLUSH)
    ) i_flush_timer (
        .clk     (cfg_clk),
        .rst_n   (clear_n),
        .capture (capture),
        .last_in (last_byte),
        .done    (flush_done)
    );

    // One-clock acknowledge pulse launched by the capturing edge
    always_ff @(posedge cfg_clk) begin
        if (!clear_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= capture;
        end
    end

    // Acknowledge pin reads high through the modelled pull-up until init releases it
    always_comb begin
        byte_taken = ack_q;
        ack_out    = init_done ? ack_q : 1'b1;
    end

endmodule

// File: rtl/cfg_ser_checker.sv
// Protocol checker for the configuration slave serializer. It is bound to
// the top module and watches only ports. Edge distances are tracked with a
// local saturating counter.
module cfg_ser_checker
    import cfg_ser_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FLUSH  = 11
) (
    input logic       clk,
    input logic       prog_n,
    input logic [2:0] mode_sel,
    input logic       byte_valid,
    input logic       byte_taken,
    input logic       ser_out,
    input logic       flush_done
);

    logic [15:0] gap_q;
    logic        seen_q;

    // Edges since the last observed acknowledge, saturating
    always_ff @(posedge clk) begin
        if (!prog_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (byte_taken) begin
                gap_q <= 16'd1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
            if (mode_sel != SYNC_PERIPH_MODE) begin
                seen_q <= 1'b0;
            end else if (byte_taken) begin
                seen_q <= 1'b1;
            end
        end
    end

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!prog_n)
        byte_taken |=> !byte_taken);

    // R3
    slot_spacing_chk: assert property (@(posedge clk) disable iff (!prog_n)
        (byte_taken && seen_q) |-> (gap_q >= 16'(DATA_W)));

    // R7
    no_false_ack_chk: assert property (@(posedge clk) disable iff (!prog_n)
        !byte_valid |=> !byte_taken);

    // R1
    mode_off_low_chk: assert property (@(posedge clk) disable iff (!prog_n)
        (mode_sel != SYNC_PERIPH_MODE) |=> !ser_out);

    // R8
    flush_count_chk: assert property (@(posedge clk) disable iff (!prog_n)
        $rose(flush_done) |-> (gap_q == 16'(FLUSH)));

endmodule

bind cfg_slave_serializer cfg_ser_checker #(
    .DATA_W (DATA_W),
    .FLUSH  (FLUSH)
) i_cfg_ser_checker (
    .clk        (cfg_clk),
    .prog_n     (prog_n),
    .mode_sel   (mode_sel),
    .byte_valid (byte_valid),
    .byte_taken (byte_taken),
    .ser_out    (ser_out),
    .flush_done (flush_done)
);

// File: tb/test_cfg_slave_serializer.sv
// Bench for the configuration slave serializer. It sweeps every byte value
// through the stream and varies the idle gaps. It also covers the pre-init,
// reset and mode cases. Expected bits come from arithmetic on the captured
// byte and its capture edge.
module test_cfg_slave_serializer;

    localparam int DW    = 8;
    localparam int BASE  = 10;
    localparam int CHAIN = 2;
    localparam int FLUSH = BASE + CHAIN;

    logic          clk = 1'b0;
    logic          prog_n, init_done, byte_valid, last_byte;
    logic [2:0]    mode_sel;
    logic [DW-1:0] data_in;
    logic          ser_out, ack_out, byte_taken, flush_done;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   last_cap = 0;
    logic chk_en = 1'b0;
    logic exp_bit [1024];

    always #2 clk = ~clk;

    cfg_slave_serializer #(
        .DATA_W     (DW),
        .BASE_FLUSH (BASE),
        .CHAIN_LEN  (CHAIN)
    ) i_cfg_slave_serializer (
        .cfg_clk    (clk),
        .prog_n     (prog_n),
        .init_done  (init_done),
        .mode_sel   (mode_sel),
        .data_in    (data_in),
        .byte_valid (byte_valid),
        .last_byte  (last_byte),
        .ser_out    (ser_out),
        .ack_out    (ack_out),
        .byte_taken (byte_taken),
        .flush_done (flush_done)
    );

    // Rising-edge index: after edge k this reads k
    always @(posedge clk) cyc <= cyc + 1;

    // Compare the serial line just after each falling edge, then recycle the slot as idle
    always @(negedge clk) begin
        #1;
        if (chk_en) begin
            checks++;
            if (ser_out !== exp_bit[cyc % 1024]) begin
                fails++;
                $display("FAIL R6 serial bit after edge %0d: got %b expected %b",
                         cyc, ser_out, exp_bit[cyc % 1024]);
            end
        end
        exp_bit[cyc % 1024] = 1'b1;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Present one byte for the next edge and walk through its slot
    task automatic push_byte(input logic [7:0] b, input logic last, input logic noise);
        int c;
        c = cyc + 1;
        last_cap   = c;
        data_in    = b;
        byte_valid = 1'b1;
        last_byte  = last;
        for (int j = 0; j < 8; j++) exp_bit[(c + 1 + j) % 1024] = b[7-j];
        tick();
        check("R4", "byte_taken on capture", byte_taken, 1);
        check("R4", "ack_out on capture", ack_out, 1);
        byte_valid = noise;
        data_in    = ~b;
        last_byte  = 1'b0;
        for (int k = 1; k < 8; k++) begin
            tick();
            check("R3", "no capture inside slot", byte_taken, 0);
        end
        byte_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_bit[i] = 1'b1;
        prog_n = 1'b0; init_done = 1'b0; mode_sel = 3'b011;
        byte_valid = 1'b0; last_byte = 1'b0; data_in = '0;
        repeat (3) tick();
        check("R9", "byte_taken in reset", byte_taken, 0);
        check("R9", "flush_done in reset", flush_done, 0);
        check("R5", "ack_out pull-up in reset", ack_out, 1);
        @(negedge clk); #1;
        check("R9", "ser_out low in reset", ser_out, 0);
        tick();
        prog_n = 1'b1;
        tick(); tick();
        check("R7", "idle level after reset", ser_out, 1);

        // R5: nothing captured before init, ack reads high
        byte_valid = 1'b1; data_in = 8'hA5;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R5", "no capture before init", byte_taken, 0);
            check("R5", "ack_out pull-up before init", ack_out, 1);
            check("R7", "idle level before init", ser_out, 1);
        end
        byte_valid = 1'b0;
        init_done = 1'b1;
        tick();
        check("R5", "ack_out released after init", ack_out, 0);

        // R6/R3: every byte value, back to back, noise on odd values
        chk_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            push_byte(8'(v), v == 255, v[0]);
            check("R8", "flush_done low while streaming", flush_done, 0);
        end
        tick();
        check("R7", "no ack on empty slot", byte_taken, 0);
        while (cyc < last_cap + FLUSH - 1) tick();
        check("R8", "flush_done before boundary", flush_done, 0);
        tick();
        check("R8", "flush_done at boundary", flush_done, 1);
        tick();

        // R2: first byte at any edge after idle gaps
        for (int g = 0; g < 10; g++) begin
            repeat (g) tick();
            push_byte(8'(g * 17 + 3), 1'b0, 1'b0);
            check("R8", "flush_done cleared by capture", flush_done, 0);
        end
        repeat (10) tick();

        // R9: program pulse in the middle of a byte
        data_in = 8'h81; byte_valid = 1'b1;
        tick();
        byte_valid = 1'b0;
        tick(); tick();
        chk_en = 1'b0;
        prog_n = 1'b0;
        tick();
        check("R9", "ack cleared by program", byte_taken, 0);
        @(negedge clk); #1;
        check("R9", "ser_out low under program", ser_out, 0);
        tick();
        prog_n = 1'b1;
        tick(); tick();
        check("R9", "idle after program release", ser_out, 1);

        // R1: every disabling mode code
        for (int m = 0; m < 8; m++) begin
            if (m != 3) begin
                mode_sel = 3'(m); byte_valid = 1'b1; data_in = 8'hFF;
                tick(); tick();
                check("R1", "no capture when disabled", byte_taken, 0);
                check("R1", "ser_out low when disabled", ser_out, 0);
            end
        end
        mode_sel = 3'b011; byte_valid = 1'b0;
        tick(); tick();
        check("R7", "idle high after re-enable", ser_out, 1);
        chk_en = 1'b1;
        push_byte(8'hC3, 1'b0, 1'b0);
        push_byte(8'h5A, 1'b0, 1'b1);
        repeat (12) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog R1-scenario run did not finish: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule